// File: doc/BRIEF.md
# Register Bit-Merge and Byte-Align Unit

This execution-stage datapath builds a new destination value from two 64-bit source operands by joining them at a boundary that the instruction gives. The boundary is either a bit count or a byte position. Each operation takes a run of bits from one operand, shifts them out of the way, and fills the vacated bits with bits from the other operand. There are two groups of operations. Word-group operations work on the low 32 bits and sign-extend the result from bit 31. Doubleword-group operations work on the full 64 bits and do no sign-extension.

The issuing stage presents the operands, a group-select input, the 5-bit sub-operation code, a 5-bit amount field and the destination register index. These are qualified by a valid strobe. One clock later the unit returns the following, all registered and aligned with a delayed valid:
- the result,
- a write-enable for the destination,
- a flag that marks an undefined sub-operation code.

A destination index of zero turns the instruction into a no-op that does not write.

Top module: `bitmerge_unit`

## Requirements
- R1: Word group, code 0x00 (shift-in-low): the low 32 bits of rt are shifted left by the amount, and the low `amount` bits are taken from rs.
- R2: Word group, code 0x01 (shift-in-high): the low 32 bits of rt are zero-extended and shifted right by the amount. The top `amount` bits of the 32-bit word are taken from the low bits of rs.
- R3: Word group, code 0x10 (byte align): only amount[1:0] is used, as the byte position bp. If bp is 0 or 2, rt passes through. If bp is 1 or 3, the result is (rt << 8·bp) | (rs[31:0] >> 8·(4−bp)).
- R4: Doubleword group, code 0x00: the low `amount` bits come from rs and the low 64−amount bits of rt sit above them.
- R5: Doubleword group, code 0x01: the result is (rt >> amount) | (rs << (64−amount)).
- R6: Doubleword group, code 0x03: the same as R5, but with an effective shift of amount|32.
- R7: Doubleword group, code 0x10: only amount[2:0] is used, as bp. If bp is 0, 2 or 4, rt passes through. Any other bp gives (rt << 8·bp) | (rs >> 8·(8−bp)).
- R8: Every written word-group result has bits 63:32 equal to bit 31. Every shift by the full width or more yields zero and does not wrap.
- R9: An amount of zero returns rt for every shifting code. In the word group this value is sign-extended from bit 31.
- R10: A destination index of zero gives write-enable low and the reserved flag low.
- R11: Any code not listed for the selected group sets the reserved flag and clears write-enable.
- R12: Result, write-enable and reserved flag appear one cycle after an accepted input, with valid high. When valid is low, write-enable and the reserved flag are low.
- R13: When no write occurs (R10 or R11), the result port carries the rt input unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input qualifier |
| dword_mode | input | 1 | 0 selects the word group, 1 selects the doubleword group |
| sub_code | input | 5 | Sub-operation code |
| amount | input | 5 | Bit count, or byte position in the low bits |
| dest_idx | input | 5 | Destination register index |
| rs_val | input | 64 | Source operand merged in |
| rt_val | input | 64 | Destination's prior value |
| out_valid | output | 1 | Output qualifier |
| out_wen | output | 1 | Write destination |
| out_rsvd | output | 1 | Undefined sub-code flag |
| out_result | output | 64 | New destination value |

## Verification
Directed cases use amounts 0, 1 and 31 and every byte position, including the pass-through positions. These separate off-by-one boundary errors from errors in choosing a rule. Operands whose bit 31 is set tell correct sign-extension apart from zero-extension. Random operands, amounts and codes, drawn both from the legal set and from the whole code space, separate the groups and check decode. Destination index zero and undefined codes check that write suppression is kept apart from the reserved flag.

// File: rtl/bitmerge_pkg.sv
package bitmerge_pkg;

  typedef enum logic [2:0] {
    MOP_NONE     = 3'd0,
    MOP_W_LOIN   = 3'd1,
    MOP_W_HIIN   = 3'd2,
    MOP_W_BYTE   = 3'd3,
    MOP_D_LOIN   = 3'd4,
    MOP_D_HIIN   = 3'd5,
    MOP_D_HIIN32 = 3'd6,
    MOP_D_BYTE   = 3'd7
  } merge_op_e;

  localparam logic [4:0] CODE_LOIN   = 5'h00;
  localparam logic [4:0] CODE_HIIN   = 5'h01;
  localparam logic [4:0] CODE_HIIN32 = 5'h03;
  localparam logic [4:0] CODE_BYTE   = 5'h10;

endpackage

// File: rtl/bitmerge_decode.sv
module bitmerge_decode
  import bitmerge_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              dword_mode,
  input  logic [CODE_W-1:0] sub_code,
  output merge_op_e         op,
  output logic              rsvd
);

  always_comb begin
    op = MOP_NONE;
    if (!dword_mode) begin
      case (sub_code)
        CODE_W'(CODE_LOIN): op = MOP_W_LOIN;
        CODE_W'(CODE_HIIN): op = MOP_W_HIIN;
        CODE_W'(CODE_BYTE): op = MOP_W_BYTE;
        default:            op = MOP_NONE;
      endcase
    end else begin
      case (sub_code)
        CODE_W'(CODE_LOIN):   op = MOP_D_LOIN;
        CODE_W'(CODE_HIIN):   op = MOP_D_HIIN;
        CODE_W'(CODE_HIIN32): op = MOP_D_HIIN32;
        CODE_W'(CODE_BYTE):   op = MOP_D_BYTE;
        default:              op = MOP_NONE;
      endcase
    end
  end

  assign rsvd = (op == MOP_NONE);

  // R3 R4: the doubleword group never decodes to a word op
  assert_group_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dword_mode && !rsvd) |-> (op >= MOP_D_LOIN));

  // R11: a code outside both legal sets is always reserved
  assert_undef_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_code != CODE_W'(CODE_LOIN) && sub_code != CODE_W'(CODE_HIIN)
     && sub_code != CODE_W'(CODE_HIIN32) && sub_code != CODE_W'(CODE_BYTE)) |-> rsvd);

endmodule

// File: rtl/bitmerge_word.sv
module bitmerge_word
  import bitmerge_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AMT_W = 5
) (
  input  merge_op_e        op,
  input  logic [AMT_W-1:0] amount,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  result
);

  localparam int HALF  = XLEN / 2;
  localparam int BYTES = HALF / 8;
  localparam int BP_W  = $clog2(BYTES);

  function automatic logic [HALF-1:0] shl_h(logic [HALF-1:0] v, int unsigned n);
    return (n >= HALF) ? '0 : (v << n);
  endfunction

  function automatic logic [HALF-1:0] shr_h(logic [HALF-1:0] v, int unsigned n);
    return (n >= HALF) ? '0 : (v >> n);
  endfunction

  function automatic logic [XLEN-1:0] sext_h(logic [HALF-1:0] v);
    return {{(XLEN-HALF){v[HALF-1]}}, v};
  endfunction

  logic [HALF-1:0]  rs_lo, rt_lo, low_mask;
  logic [BP_W-1:0]  bpos;
  int unsigned      sa, bshift;
  logic [HALF-1:0]  w_loin, w_hiin, w_byte, w_sel;

  assign rs_lo    = rs_val[HALF-1:0];
  assign rt_lo    = rt_val[HALF-1:0];
  assign sa       = int'(amount);
  assign bpos     = amount[BP_W-1:0];
  assign bshift   = 8 * int'(bpos);
  assign low_mask = ~shl_h('1, sa);

  assign w_loin = shl_h(rt_lo, sa) | (rs_lo & low_mask);
  assign w_hiin = shr_h(rt_lo, sa) | shl_h(rs_lo, HALF - sa);
  assign w_byte = bpos[0] ? (shl_h(rt_lo, bshift) | shr_h(rs_lo, HALF - bshift)) : rt_lo;

  always_comb begin
    case (op)
      MOP_W_LOIN: w_sel = w_loin;
      MOP_W_HIIN: w_sel = w_hiin;
      MOP_W_BYTE: w_sel = w_byte;
      default:    w_sel = rt_lo;
    endcase
  end

  assign result = sext_h(w_sel);

endmodule

// File: rtl/bitmerge_dword.sv
module bitmerge_dword
  import bitmerge_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AMT_W = 5
) (
  input  merge_op_e        op,
  input  logic [AMT_W-1:0] amount,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  result
);

  localparam int HALF  = XLEN / 2;
  localparam int BYTES = XLEN / 8;
  localparam int BP_W  = $clog2(BYTES);

  function automatic logic [XLEN-1:0] shl_d(logic [XLEN-1:0] v, int unsigned n);
    return (n >= XLEN) ? '0 : (v << n);
  endfunction

  function automatic logic [XLEN-1:0] shr_d(logic [XLEN-1:0] v, int unsigned n);
    return (n >= XLEN) ? '0 : (v >> n);
  endfunction

  logic [BP_W-1:0] bpos;
  int unsigned     sa, sa_hi, bshift;
  logic            keep_rt;
  logic [XLEN-1:0] d_loin, d_hiin, d_hiin32, d_byte;

  assign sa     = int'(amount);
  assign sa_hi  = sa | HALF;
  assign bpos   = amount[BP_W-1:0];
  assign bshift = 8 * int'(bpos);
  // positions 0, 2 and 4 pass rt through; 1, 3, 5, 6 and 7 merge
  assign keep_rt = (bpos == BP_W'(0)) || (bpos == BP_W'(2)) || (bpos == BP_W'(4));

  assign d_loin   = shl_d(rt_val, sa) | (rs_val & ~shl_d('1, sa));
  assign d_hiin   = shr_d(rt_val, sa) | shl_d(rs_val, XLEN - sa);
  assign d_hiin32 = shr_d(rt_val, sa_hi) | shl_d(rs_val, XLEN - sa_hi);
  assign d_byte   = keep_rt ? rt_val : (shl_d(rt_val, bshift) | shr_d(rs_val, XLEN - bshift));

  always_comb begin
    case (op)
      MOP_D_LOIN:   result = d_loin;
      MOP_D_HIIN:   result = d_hiin;
      MOP_D_HIIN32: result = d_hiin32;
      MOP_D_BYTE:   result = d_byte;
      default:      result = rt_val;
    endcase
  end

endmodule

// File: rtl/bitmerge_unit.sv
module bitmerge_unit
  import bitmerge_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int AMT_W  = 5,
  parameter int CODE_W = 5,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              dword_mode,
  input  logic [CODE_W-1:0] sub_code,
  input  logic [AMT_W-1:0]  amount,
  input  logic [IDX_W-1:0]  dest_idx,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic              out_valid,
  output logic              out_wen,
  output logic              out_rsvd,
  output logic [XLEN-1:0]   out_result
);

  localparam int HALF = XLEN / 2;

  merge_op_e       dec_op;
  logic            dec_rsvd;
  logic            dest_zero;
  logic            do_write;
  logic [XLEN-1:0] word_res, dword_res, next_res;

  bitmerge_decode #(.CODE_W(CODE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .dword_mode(dword_mode), .sub_code(sub_code),
    .op(dec_op), .rsvd(dec_rsvd)
  );

  bitmerge_word #(.XLEN(XLEN), .AMT_W(AMT_W)) u_word (
    .op(dec_op), .amount(amount), .rs_val(rs_val), .rt_val(rt_val), .result(word_res)
  );

  bitmerge_dword #(.XLEN(XLEN), .AMT_W(AMT_W)) u_dword (
    .op(dec_op), .amount(amount), .rs_val(rs_val), .rt_val(rt_val), .result(dword_res)
  );

  assign dest_zero = (dest_idx == '0);
  // a zero destination is a plain no-op: it is not decoded and cannot be reserved
  assign do_write  = !dest_zero && !dec_rsvd;
  assign next_res  = !do_write ? rt_val : (dword_mode ? dword_res : word_res);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_wen    <= 1'b0;
      out_rsvd   <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      out_wen   <= in_valid && do_write;
      out_rsvd  <= in_valid && !dest_zero && dec_rsvd;
      if (in_valid) out_result <= next_res;
    end
  end

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_wen && !out_rsvd));

  assert_zero_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dest_zero) |=> (!out_wen && !out_rsvd));

  assert_rsvd_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_rsvd |-> !out_wen);

  assert_word_sext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dword_mode && do_write) |=>
      (out_result[XLEN-1:HALF] == {HALF{out_result[HALF-1]}}));

  assert_nowrite_keeps_rt_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !do_write) |=> (out_result == $past(rt_val)));

endmodule

// File: tb/sim_bitmerge_unit.sv
module sim_bitmerge_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        dword_mode = 1'b0;
  logic [4:0]  sub_code = '0;
  logic [4:0]  amount = '0;
  logic [4:0]  dest_idx = '0;
  logic [63:0] rs_val = '0;
  logic [63:0] rt_val = '0;
  logic        out_valid, out_wen, out_rsvd;
  logic [63:0] out_result;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bitmerge_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dword_mode(dword_mode),
    .sub_code(sub_code), .amount(amount), .dest_idx(dest_idx),
    .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid), .out_wen(out_wen),
    .out_rsvd(out_rsvd), .out_result(out_result)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // bitwise reference: each result bit is picked from rt or rs by position
  function automatic logic [63:0] ref_value(bit dw, logic [4:0] code, logic [4:0] amt,
                                            logic [63:0] rs, logic [63:0] rt, output bit legal);
    logic [63:0] r;
    int sa, bp, eff;
    r = rt;
    legal = 1;
    sa = int'(amt);
    if (!dw) begin
      logic [31:0] w;
      w = rt[31:0];
      if (code == 5'h00) begin          // R1
        for (int i = 0; i < 32; i++) w[i] = (i < sa) ? rs[i] : rt[i - sa];
      end else if (code == 5'h01) begin // R2
        for (int i = 0; i < 32; i++) w[i] = (i + sa < 32) ? rt[i + sa] : rs[i + sa - 32];
      end else if (code == 5'h10) begin // R3
        bp = sa % 4;
        if (bp == 1 || bp == 3)
          for (int i = 0; i < 32; i++) w[i] = (i >= 8*bp) ? rt[i - 8*bp] : rs[i + 32 - 8*bp];
      end else legal = 0;
      r = {{32{w[31]}}, w};             // R8
    end else begin
      if (code == 5'h00) begin          // R4
        for (int i = 0; i < 64; i++) r[i] = (i < sa) ? rs[i] : rt[i - sa];
      end else if (code == 5'h01 || code == 5'h03) begin // R5 R6
        eff = (code == 5'h03) ? (sa | 32) : sa;
        for (int i = 0; i < 64; i++) r[i] = (i + eff < 64) ? rt[i + eff] : rs[i + eff - 64];
      end else if (code == 5'h10) begin // R7
        bp = sa % 8;
        if (!(bp == 0 || bp == 2 || bp == 4))
          for (int i = 0; i < 64; i++) r[i] = (i >= 8*bp) ? rt[i - 8*bp] : rs[i + 64 - 8*bp];
      end else legal = 0;
    end
    return r;
  endfunction

  task automatic run_op(string req, bit dw, logic [4:0] code, logic [4:0] amt,
                        logic [4:0] dst, logic [63:0] rs, logic [63:0] rt);
    bit legal, wr;
    logic [63:0] exp;
    exp = ref_value(dw, code, amt, rs, rt, legal);
    wr = legal && (dst != 0);
    if (!wr) exp = rt;                  // R13
    @(negedge clk);
    in_valid = 1; dword_mode = dw; sub_code = code; amount = amt;
    dest_idx = dst; rs_val = rs; rt_val = rt;
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid R12"}, 64'(out_valid), 64'd1);
    chk({req, " wen"}, 64'(out_wen), 64'(wr));
    chk({req, " rsvd R11"}, 64'(out_rsvd), 64'(!legal && dst != 0));
    chk({req, " result"}, out_result, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] codes [5];
    void'($urandom(32'd1357));
    codes[0] = 5'h00; codes[1] = 5'h01; codes[2] = 5'h03; codes[3] = 5'h10; codes[4] = 5'h07;
    repeat (3) @(negedge clk);
    chk("reset valid R12", 64'(out_valid), 64'd0);
    chk("reset wen R12", 64'(out_wen), 64'd0);
    chk("reset rsvd R12", 64'(out_rsvd), 64'd0);
    rst_n = 1;

    // directed corners
    run_op("R1 amt1",  0, 5'h00, 5'd1,  5'd3, 64'h0, 64'h0000_0000_4000_0001);
    run_op("R1 amt31", 0, 5'h00, 5'd31, 5'd3, 64'h7FFF_FFFF, 64'h1);
    run_op("R9 loin0", 0, 5'h00, 5'd0,  5'd3, 64'hFFFF_FFFF, 64'h1234_5678_8000_0000);
    run_op("R2 amt4",  0, 5'h01, 5'd4,  5'd3, 64'h5, 64'hFFFF_FFFF_1234_5678);
    run_op("R9 hiin0", 0, 5'h01, 5'd0,  5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_7000_0000);
    for (int b = 0; b < 8; b++)
      run_op("R3 bp", 0, 5'h10, 5'(b), 5'd7, 64'hA1B2_C3D4_E5F6_0718, 64'h1122_3344_5566_7788);
    run_op("R4 amt8",  1, 5'h00, 5'd8,  5'd1, 64'hFF, 64'h8000_0000_0000_0001);
    run_op("R9 dloin0",1, 5'h00, 5'd0,  5'd1, 64'hFFFF, 64'hDEAD_BEEF_0BAD_F00D);
    run_op("R5 amt16", 1, 5'h01, 5'd16, 5'd1, 64'hBEEF, 64'h1111_2222_3333_4444);
    run_op("R9 dhiin0",1, 5'h01, 5'd0,  5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF);
    run_op("R6 amt0",  1, 5'h03, 5'd0,  5'd1, 64'hCAFE, 64'h8765_4321_0000_0000);
    run_op("R6 amt31", 1, 5'h03, 5'd31, 5'd1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int b = 0; b < 8; b++)
      run_op("R7 bp", 1, 5'h10, 5'(b), 5'd9, 64'hA1B2_C3D4_E5F6_0718, 64'h1122_3344_5566_7788);
    run_op("R10 dst0", 0, 5'h00, 5'd5,  5'd0, 64'h1F, 64'h0000_0000_8000_0000);
    run_op("R10 dst0 undef", 1, 5'h02, 5'd5, 5'd0, 64'h1F, 64'h55);
    run_op("R11 w03",  0, 5'h03, 5'd5,  5'd4, 64'h1F, 64'hFFFF_0000_8000_0000);
    run_op("R11 d11",  1, 5'h11, 5'd5,  5'd4, 64'h1F, 64'h77);
    @(negedge clk);
    chk("idle valid R12", 64'(out_valid), 64'd0);
    chk("idle wen R12", 64'(out_wen), 64'd0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [4:0] code;
      code = ($urandom % 4 == 0) ? 5'($urandom) : codes[$urandom % 5];
      run_op("R8 random", 1'($urandom), code, 5'($urandom), 5'($urandom % 8),
             {$urandom, $urandom}, {$urandom, $urandom});
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule